// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write an external 8K x 8 asynchronous static RAM. The memory is selected only when its active-low select is low and its active-high select is high. A low write strobe writes, and a low read strobe (output enable) puts data on the pins. The controller turns single user requests into correctly timed strobe sequences. Every strobe width, setup, hold and turnaround is a whole number of clock cycles. Each count is derived from a nanosecond figure and the clock period, rounded up.

On the user side a request is taken on a cycle where `req` and `ready` are both high. The request carries an address, write data and a read/write flag. `ready` stays low for the whole access. A read returns its data with a single-cycle `rd_valid` pulse. On the memory side the block drives the address, both selects and both strobes. It also drives outgoing data with a separate drive-enable, so the board-level tri-state buffer sits outside. The drive-enable is sequenced so that the controller and the memory never drive the data pins at the same time.

Top module: `sram_access_ctrl`

## Requirements
- R1: After reset `ready`=1, `mem_sel_n`=1, `mem_sel`=0, `mem_wr_n`=1, `mem_rd_n`=1, `mem_dq_oe`=0 and `rd_valid`=0.
- R2: A request is accepted only on a rising edge where `req`=1 and `ready`=1. `ready` is 0 from the next cycle until the access ends. A `req` seen while `ready`=0 has no effect.
- R3: A strobe (`mem_wr_n`=0 or `mem_rd_n`=0) is only ever asserted while `mem_sel_n`=0 and `mem_sel`=1 together.
- R4: A read holds `mem_rd_n`=0, `mem_wr_n`=1 and `mem_dq_oe`=0 for N_RD cycles. N_RD is the larger of the rounded-up address and output-enable access times. The data is captured on the last of those edges and presented with a one-cycle `rd_valid` pulse.
- R5: A write keeps `mem_rd_n`=1 throughout. One setup cycle with the address and selects applied comes first. Then `mem_wr_n`=0 for N_WP cycles. N_WP is at least the rounded-up write pulse, the address-to-end-of-write time and the turn-off time plus the data setup time.
- R6: `mem_dq_oe` rises only after `mem_wr_n` has been low for N_WHZ cycles (rounded-up memory turn-off time). It stays high exactly one cycle after `mem_wr_n` rises and is never high while `mem_rd_n`=0.
- R7: `mem_addr` and `mem_dq_o` change only in a cycle that follows one where the memory was deselected and both strobes were high.
- R8: After a read, the read strobe and selects are released for N_TURN cycles (rounded-up memory disable time) before `ready` returns. The memory is never driving while `mem_dq_oe`=1.
- R9: With the default 20 ns clock, a write keeps `ready` low 4 cycles with `mem_wr_n` low 2 cycles. A read keeps `ready` low 2 cycles.
- R10: Data written to any address, including 0x0000 and 0x1FFF, is returned by a later read of that address. A later write to the same address replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Access address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Controller idle, request may be given |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` valid |
| mem_addr | output | 13 | Memory address bus |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 8 | Data from memory |

## Verification
On every cycle the assertions check that strobes only occur with both selects active, and that the read strobe and the controller's driver are never on together. They also check that the driver rises only after the write strobe has been low and that the address and outgoing data stay frozen unless the memory was idle. The `rd_valid` pulse is checked to be one cycle wide. Only the bench scenarios can show that data written reaches the right location and comes back. The same holds for the exact cycle counts that follow from the nanosecond figures, and for a request raised while busy being dropped. The bench's memory model also measures real strobe widths and setup times in nanoseconds.

// File: rtl/sram_acc_pkg.sv
package sram_acc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RTURN
  } acc_state_t;

  // whole cycles covering a time in ps, at least one
  function automatic int cycles_for(input int t_ps, input int clk_ps);
    int n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_acc_datapath.sv
module sram_acc_datapath #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (load) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr = addr_q;
  assign mem_dq_o = wdata_q;
  assign rd_data  = rdata_q;

endmodule

// File: rtl/sram_acc_fsm.sv
module sram_acc_fsm
  import sram_acc_pkg::*;
#(
  parameter int N_RD   = 1,
  parameter int N_WP   = 2,
  parameter int N_WHZ  = 1,
  parameter int N_TURN = 1,
  parameter int CNT_W  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic req_we,
  output logic ready,
  output logic load,
  output logic capture,
  output logic rd_valid,
  output logic mem_sel_n,
  output logic mem_sel,
  output logic mem_wr_n,
  output logic mem_rd_n,
  output logic mem_dq_oe
);

  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] WP_LAST   = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(N_TURN - 1);
  localparam logic [CNT_W-1:0] DRV_AT    = CNT_W'(N_WHZ - 1);

  acc_state_t       state;
  logic [CNT_W-1:0] cnt;

  assign load    = ready && req;
  assign capture = (state == ST_RACC) && (cnt == RD_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      ready     <= 1'b1;
      rd_valid  <= 1'b0;
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_wr_n  <= 1'b1;
      mem_rd_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req) begin
            ready     <= 1'b0;
            mem_sel_n <= 1'b0;
            mem_sel   <= 1'b1;
            cnt       <= '0;
            if (req_we) begin
              state <= ST_WSETUP;
            end else begin
              state    <= ST_RACC;
              mem_rd_n <= 1'b0;
            end
          end
        end
        ST_WSETUP: begin
          mem_wr_n <= 1'b0;
          cnt      <= '0;
          state    <= ST_WPULSE;
        end
        ST_WPULSE: begin
          if (cnt >= DRV_AT) mem_dq_oe <= 1'b1;
          if (cnt == WP_LAST) begin
            mem_wr_n <= 1'b1;
            state    <= ST_WHOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WHOLD: begin
          mem_dq_oe <= 1'b0;
          mem_sel_n <= 1'b1;
          mem_sel   <= 1'b0;
          ready     <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_RACC: begin
          if (cnt == RD_LAST) begin
            mem_rd_n  <= 1'b1;
            mem_sel_n <= 1'b1;
            mem_sel   <= 1'b0;
            rd_valid  <= 1'b1;
            cnt       <= '0;
            state     <= ST_RTURN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RTURN: begin
          if (cnt == TURN_LAST) begin
            ready <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: strobes only with both selects active
  a_r3_strobe_needs_select: assert property (@(posedge clk) disable iff (rst)
    (!mem_wr_n || !mem_rd_n) |-> (!mem_sel_n && mem_sel));

  // R4: read strobe never with write strobe or own driver
  a_r4_read_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |-> (mem_wr_n && !mem_dq_oe));

  // R4: read data valid is a single-cycle pulse
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R6: driver turns on only after the write strobe has been low
  a_r6_drive_after_wr: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (!mem_wr_n && !$past(mem_wr_n)));

  // R6: driver released one cycle after the write strobe rises
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_n) |-> mem_dq_oe ##1 !mem_dq_oe);

  // R2: idle controller keeps the memory deselected
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_sel_n && mem_wr_n && mem_rd_n && !mem_dq_oe));

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_acc_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 20000,
  parameter int T_WP_PS   = 8000,
  parameter int T_WC_PS   = 10000,
  parameter int T_AW_PS   = 8000,
  parameter int T_DW_PS   = 6000,
  parameter int T_WHZ_PS  = 6000,
  parameter int T_AA_PS   = 10000,
  parameter int T_OE_PS   = 5000,
  parameter int T_OHZ_PS  = 5000,
  parameter int T_CHZ_PS  = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_wr_n,
  output logic              mem_rd_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int N_WHZ  = cycles_for(T_WHZ_PS, CLK_PS);
  localparam int N_DW   = cycles_for(T_DW_PS, CLK_PS);
  // whole write = setup + pulse + hold must cover the write cycle time
  localparam int N_WP   = imax(imax(cycles_for(T_WP_PS, CLK_PS), cycles_for(T_AW_PS, CLK_PS)),
                               imax(N_WHZ + N_DW, cycles_for(T_WC_PS, CLK_PS) - 2));
  localparam int N_RD   = imax(cycles_for(T_AA_PS, CLK_PS), cycles_for(T_OE_PS, CLK_PS));
  localparam int N_TURN = imax(cycles_for(T_OHZ_PS, CLK_PS), cycles_for(T_CHZ_PS, CLK_PS));
  localparam int N_MAX  = imax(imax(N_WP, N_RD), N_TURN);
  localparam int CNT_W  = $clog2(N_MAX + 1);

  logic load;
  logic capture;

  sram_acc_fsm #(
    .N_RD   (N_RD),
    .N_WP   (N_WP),
    .N_WHZ  (N_WHZ),
    .N_TURN (N_TURN),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .req_we    (req_we),
    .ready     (ready),
    .load      (load),
    .capture   (capture),
    .rd_valid  (rd_valid),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_wr_n  (mem_wr_n),
    .mem_rd_n  (mem_rd_n),
    .mem_dq_oe (mem_dq_oe)
  );

  sram_acc_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .rd_data   (rd_data)
  );

  // R7: address moves only after an idle, deselected cycle
  a_r7_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr) |-> ($past(mem_sel_n) && $past(mem_wr_n) && $past(mem_rd_n)));

  // R7: outgoing data never changes under the driver
  a_r7_data_frozen: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_dq_o) |-> !$past(mem_dq_oe));

  // R8: after the read strobe releases, driver stays off during turnaround
  a_r8_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_n) |-> !mem_dq_oe);

endmodule

// File: tb/test_sram_access_ctrl.sv
`timescale 1ns/1ps
module test_sram_access_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [12:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i;

  int errors = 0;
  int checks = 0;
  int viol   = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sram_access_ctrl i_sram_access_ctrl (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // ---------------- behavioural memory model ----------------
  logic [7:0] mem [logic [12:0]];
  wire  sel     = !mem_sel_n && mem_sel;
  wire  mem_drv = sel && !mem_rd_n && mem_wr_n;
  realtime t_wr_fall = 0.0, t_drv_rise = 0.0, t_rd_fall = 0.0;

  function automatic logic [7:0] mem_rd(input logic [12:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  assign mem_dq_i = mem_drv ? mem_rd(mem_addr) : 8'h00;

  always @(negedge mem_wr_n) t_wr_fall = $realtime;
  always @(posedge mem_dq_oe) t_drv_rise = $realtime;
  always @(negedge mem_rd_n) t_rd_fall = $realtime;

  always @(posedge mem_wr_n) begin
    if (!rst && sel) begin
      if ($realtime - t_wr_fall < 8.0) viol++;
      if (!mem_dq_oe || ($realtime - t_drv_rise < 6.0)) viol++;
      mem[mem_addr] = mem_dq_o;
    end
  end

  always @(posedge mem_rd_n) begin
    if (!rst && ($realtime - t_rd_fall < 10.0)) viol++;
  end

  always @(mem_addr) begin
    if (!rst && sel && !mem_wr_n) viol++;
  end

  always @(negedge clk) begin
    if (!rst && mem_dq_oe && mem_drv) viol++;
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // one access; reports read data and observed cycle counts
  task automatic access(input bit we, input logic [12:0] a, input logic [7:0] d,
                        output logic [7:0] rdat, output int busy,
                        output int wr_lo, output int vcnt);
    busy = 0; wr_lo = 0; vcnt = 0; rdat = '0;
    while (!ready) @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    while (!ready) begin
      busy++;
      if (!mem_wr_n) wr_lo++;
      if (rd_valid) begin vcnt++; rdat = rd_data; end
      @(negedge clk);
    end
    if (rd_valid) begin vcnt++; rdat = rd_data; end
  endtask

  // {write flag, address, data or expected read data}
  localparam logic [21:0] VEC [12] = '{
    {1'b1, 13'h0000, 8'hA5},
    {1'b1, 13'h1FFF, 8'h5A},
    {1'b1, 13'h0155, 8'h3C},
    {1'b1, 13'h0AAA, 8'hC3},
    {1'b0, 13'h0000, 8'hA5},
    {1'b0, 13'h1FFF, 8'h5A},
    {1'b0, 13'h0155, 8'h3C},
    {1'b0, 13'h0AAA, 8'hC3},
    {1'b1, 13'h0155, 8'h99},
    {1'b0, 13'h0155, 8'h99},
    {1'b0, 13'h1FFF, 8'h5A},
    {1'b0, 13'h0000, 8'hA5}
  };

  initial begin
    logic [7:0] rd;
    int busy, wlo, vc;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ready == 1'b1, "R1", "ready", ready, 1);
    chk(mem_sel_n == 1'b1 && mem_sel == 1'b0, "R1", "selects", {mem_sel_n, mem_sel}, 2);
    chk(mem_wr_n && mem_rd_n, "R1", "strobes", {mem_wr_n, mem_rd_n}, 3);
    chk(!mem_dq_oe && !rd_valid, "R1", "driver/valid", {mem_dq_oe, rd_valid}, 0);
    rst = 1'b0;
    @(negedge clk);

    // table walk: R4 R5 R9 R10
    for (int i = 0; i < 12; i++) begin
      access(VEC[i][21], VEC[i][20:8], VEC[i][7:0], rd, busy, wlo, vc);
      if (VEC[i][21]) begin
        chk(busy == 4, "R9", "write busy cycles", busy, 4);
        chk(wlo == 2, "R5", "write strobe cycles", wlo, 2);
        chk(vc == 0, "R4", "no valid on write", vc, 0);
      end else begin
        chk(busy == 2, "R9", "read busy cycles", busy, 2);
        chk(vc == 1, "R4", "valid pulse count", vc, 1);
        chk(rd == VEC[i][7:0], "R10", "read data", rd, VEC[i][7:0]);
      end
    end

    // R2: request while busy is ignored
    while (!ready) @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 13'h0010; req_wdata = 8'h11;
    @(negedge clk);
    req_addr = 13'h0020; req_wdata = 8'h77;   // still high while ready is low
    chk(ready == 1'b0, "R2", "ready low after accept", ready, 0);
    @(negedge clk);
    req = 1'b0;
    while (!ready) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk(ready == 1'b1 && mem_sel_n, "R2", "no hidden access", ready, 1);
    end
    access(1'b0, 13'h0020, 8'h00, rd, busy, wlo, vc);
    chk(rd == 8'h00, "R2", "busy request not written", rd, 0);
    access(1'b0, 13'h0010, 8'h00, rd, busy, wlo, vc);
    chk(rd == 8'h11, "R2", "accepted write landed", rd, 8'h11);

    // R8: read straight into write, then read back
    access(1'b0, 13'h0AAA, 8'h00, rd, busy, wlo, vc);
    access(1'b1, 13'h0AAB, 8'h6E, rd, busy, wlo, vc);
    access(1'b0, 13'h0AAB, 8'h00, rd, busy, wlo, vc);
    chk(rd == 8'h6E, "R8", "turnaround write readback", rd, 8'h6E);

    // R3 R6 R7 R8: model saw no timing violation or contention
    chk(viol == 0, "R6", "memory model violations", viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule